// File: doc/BRIEF.md
# PLL Bring-Up and Shutdown Sequencer

This block runs a PLL through its start and stop procedures in hardware. It drives the PLL's 32-bit control word, watches the PLL's lock status, and moves the system clock selector during bring-up. A start request first checks whether the PLL is already running. If it is not, the block loads the multiply and divide factors, pulses the PLL reset low-high-low and polls for lock. While it waits, it raises a slip-clear strobe on every poll that finds lock incomplete. Once lock is seen, it removes bypass and enables the output. A stop request sets bypass before it powers the PLL down, so clocks that are derived from the PLL keep running on the raw input.

A request flagged as primary parks the system clock on the raw input for the whole bring-up and hands it back to the PLL once the output is enabled. A primary PLL reports lock on a two-bit field. Every other PLL uses a single bit. A lock that never arrives ends the sequence with an error flag after a parameterised number of polls. The block also derives, from the control word and the input rate, the output rate the PLL should produce, so that checkers can compare against it.

The requests, the lock field and the status pins are plain level or pulse signals. Nothing here carries a data stream, so the block has no valid/ready handshake. A request is taken only while the block is idle. A request that arrives while it is busy is dropped and is not held.

Top module: `pll_seq_top`

## Requirements
- R1: After reset, ctrl_word is 0x0080_0000 (only bypass, bit 23, set), and sysclk_sel, busy, done, err and slip_clr are all 0.
- R2: A start request finds the PLL already running when ctrl_word has bit 20 (reset) clear and both bit 21 (power) and bit 25 (enable) set. Such a request is ignored: busy and done stay 0 and ctrl_word does not change.
- R3: On an accepted primary start, sysclk_sel is 0 (raw input) from the cycle after acceptance and becomes 1 one cycle after the enable write. A non-primary start leaves sysclk_sel unchanged.
- R4: One cycle after acceptance, ctrl_word bits 19:0 hold {bw[5:0], od[3:0], f[5:0], r[3:0]} (r in bits 3:0, f in 9:4, od in 13:10, bw in 19:14), with bit 21 set and bypass still set.
- R5: After the factor write, bit 20 is written 0 for one cycle, then held 1 for RST_HI_CYC cycles (default 2), then written 0. Only then does lock polling begin.
- R6: Lock is complete when lock_i is 2'b11 for a primary start. For a non-primary start only lock_i[0] is used, and lock_i[1] is ignored.
- R7: Each polling cycle that finds lock incomplete pulses slip_clr for one cycle.
- R8: One cycle after lock is seen, a single write clears bypass (bit 23) and sets enable (bit 25).
- R9: On a stop request, bit 23 is set in the following cycle with power and enable unchanged. In the cycle after that, bits 21 and 25 are cleared.
- R10: busy is 1 from the cycle after an accepted request until the final write of the sequence. done is 1 for exactly one cycle, in the cycle of that final write, while busy is 0. Requests arriving while busy are ignored.
- R11: If lock has not come after LOCK_TMO polls, err is set, busy drops, done stays 0 and enable is not set. err clears when the next request is accepted.
- R12: rate_exp equals fin_rate while bypass is set. With bypass clear and power on, it equals fin_rate*(F+1)/((R+1)*(OD+1)), taken from the control word fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Start request, sampled while idle |
| stop_req | input | 1 | Stop request, sampled while idle; start wins if both are high |
| primary_i | input | 1 | Marks the request as the primary PLL |
| cfg_r | input | 4 | Reference divider value R |
| cfg_f | input | 6 | Feedback multiplier value F |
| cfg_od | input | 4 | Output divider value OD |
| cfg_bw | input | 6 | Bandwidth adjust value |
| lock_i | input | 2 | PLL lock field |
| fin_rate | input | 32 | Input reference rate |
| ctrl_word | output | 32 | PLL control word |
| sysclk_sel | output | 1 | System clock source: 0 raw input, 1 PLL |
| slip_clr | output | 1 | Clear-slip strobe; in the lock status register this bit sits at the lock field offset + 2 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Lock timeout flag |
| rate_exp | output | 38 | Expected PLL output rate |

## Verification
Take edge 0 as the edge that accepts a start. The factor word is then due after edge 1, and the reset bit is low after edge 2, high after edges 3 and 4, and low again after edge 5. Each later edge is one poll. The enable word follows the poll that sees lock by exactly one edge, and for a primary start the selector and done follow one edge after that. A stop shows bypass after the accepting edge and power-down with done one edge later. The bench drives every input on the falling edge and checks each output at the falling edge right after the rising edge that should have produced it. A timeout is checked both one poll early (no error) and on the LOCK_TMO-th poll (error).

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int CW_W   = 32;
  localparam int R_LSB  = 0;
  localparam int F_LSB  = 4;
  localparam int OD_LSB = 10;
  localparam int BW_LSB = 14;
  localparam int FAC_W  = 20;
  localparam int B_RST  = 20;
  localparam int B_PWR  = 21;
  localparam int B_BYP  = 23;
  localparam int B_EN   = 25;
  localparam logic [CW_W-1:0] CTRL_RST = CW_W'(1) << B_BYP;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_RLO, ST_RSET, ST_RHI, ST_WAIT, ST_SELPLL, ST_STOP
  } seq_state_e;
endpackage

// File: rtl/pll_seq_lock.sv
module pll_seq_lock #(
  parameter int PRI_W = 2,
  parameter int SEC_W = 1
) (
  input  logic [PRI_W-1:0] lock_i,
  input  logic             primary,
  output logic             locked
);
  always_comb begin
    if (primary) locked = &lock_i;
    else         locked = &lock_i[SEC_W-1:0];
  end
endmodule

// File: rtl/pll_seq_rate.sv
module pll_seq_rate
  import pll_seq_pkg::*;
#(
  parameter int FIN_W  = 32,
  parameter int RATE_W = FIN_W + 6
) (
  input  logic [FIN_W-1:0]  fin,
  input  logic [CW_W-1:0]   ctrl,
  output logic [RATE_W-1:0] rate
);
  localparam int NUM_W = FIN_W + 7;
  logic [NUM_W-1:0] num, quo;
  logic [8:0]       den;
  logic [6:0]       fmul;

  always_comb begin
    fmul = {1'b0, ctrl[F_LSB +: 6]} + 7'd1;
    num  = NUM_W'(fin) * NUM_W'(fmul);
    den  = ({5'b0, ctrl[R_LSB +: 4]} + 9'd1) * ({5'b0, ctrl[OD_LSB +: 4]} + 9'd1);
    quo  = num / NUM_W'(den);
    if (ctrl[B_BYP])       rate = RATE_W'(fin);
    else if (!ctrl[B_PWR]) rate = '0;
    else                   rate = quo[RATE_W-1:0];
  end
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int RST_HI_CYC = 2,
  parameter int LOCK_TMO   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             primary_i,
  input  logic [FAC_W-1:0] fac_i,
  input  logic             locked,
  output logic             prim_q,
  output logic [CW_W-1:0]  ctrl_q,
  output logic             sel_q,
  output logic             slip_q,
  output logic             busy_q,
  output logic             done_q,
  output logic             err_q
);
  localparam int MAXC  = (LOCK_TMO > RST_HI_CYC) ? LOCK_TMO : RST_HI_CYC;
  localparam int CNT_W = $clog2(MAXC) + 1;
  localparam logic [CNT_W-1:0] RHI_LAST = CNT_W'(RST_HI_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(LOCK_TMO - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [FAC_W-1:0] fac_q;
  logic             running;

  assign running = !ctrl_q[B_RST] && ctrl_q[B_PWR] && ctrl_q[B_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ctrl_q  <= CTRL_RST;
      sel_q   <= 1'b0;
      slip_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      prim_q  <= 1'b0;
      cnt_q   <= '0;
      fac_q   <= '0;
    end else begin
      done_q <= 1'b0;
      slip_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_req && !running) begin
            busy_q  <= 1'b1;
            err_q   <= 1'b0;
            prim_q  <= primary_i;
            fac_q   <= fac_i;
            if (primary_i) sel_q <= 1'b0;
            state_q <= ST_PROG;
          end else if (stop_req && !start_req) begin
            ctrl_q[B_BYP] <= 1'b1;
            busy_q  <= 1'b1;
            err_q   <= 1'b0;
            state_q <= ST_STOP;
          end
        end
        ST_PROG: begin
          ctrl_q[FAC_W-1:0] <= fac_q;
          ctrl_q[B_PWR]     <= 1'b1;
          state_q           <= ST_RLO;
        end
        ST_RLO: begin
          ctrl_q[B_RST] <= 1'b0;
          state_q       <= ST_RSET;
        end
        ST_RSET: begin
          ctrl_q[B_RST] <= 1'b1;
          cnt_q         <= '0;
          state_q       <= ST_RHI;
        end
        ST_RHI: begin
          if (cnt_q == RHI_LAST) begin
            ctrl_q[B_RST] <= 1'b0;
            cnt_q         <= '0;
            state_q       <= ST_WAIT;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (locked) begin
            ctrl_q[B_BYP] <= 1'b0;
            ctrl_q[B_EN]  <= 1'b1;
            if (prim_q) begin
              state_q <= ST_SELPLL;
            end else begin
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end else if (cnt_q == TMO_LAST) begin
            err_q   <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            slip_q <= 1'b1;
            cnt_q  <= cnt_q + 1'b1;
          end
        end
        ST_SELPLL: begin
          sel_q   <= 1'b1;
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_STOP: begin
          ctrl_q[B_PWR] <= 1'b0;
          ctrl_q[B_EN]  <= 1'b0;
          busy_q        <= 1'b0;
          done_q        <= 1'b1;
          state_q       <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  assert_slip_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slip_q |-> (busy_q && !ctrl_q[B_EN]));
  assert_reset_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q[B_RST]) |-> $past(ctrl_q[B_RST], 2));
  assert_enable_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[B_EN]) |-> (!ctrl_q[B_BYP] && $past(locked)));
  assert_stop_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q[B_PWR]) |-> $past(ctrl_q[B_BYP]));
  assert_sel_after_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_q) |-> (ctrl_q[B_EN] && prim_q));
  assert_tmo_no_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (!ctrl_q[B_EN] && !busy_q && !done_q));
endmodule

// File: rtl/pll_seq_top.sv
module pll_seq_top
  import pll_seq_pkg::*;
#(
  parameter int FIN_W      = 32,
  parameter int RATE_W     = FIN_W + 6,
  parameter int RST_HI_CYC = 2,
  parameter int LOCK_TMO   = 64,
  parameter int PRI_LOCK_W = 2,
  parameter int SEC_LOCK_W = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_req,
  input  logic                  stop_req,
  input  logic                  primary_i,
  input  logic [3:0]            cfg_r,
  input  logic [5:0]            cfg_f,
  input  logic [3:0]            cfg_od,
  input  logic [5:0]            cfg_bw,
  input  logic [PRI_LOCK_W-1:0] lock_i,
  input  logic [FIN_W-1:0]      fin_rate,
  output logic [CW_W-1:0]       ctrl_word,
  output logic                  sysclk_sel,
  output logic                  slip_clr,
  output logic                  busy,
  output logic                  done,
  output logic                  err,
  output logic [RATE_W-1:0]     rate_exp
);
  logic             locked, prim;
  logic [FAC_W-1:0] fac;

  assign fac = {cfg_bw, cfg_od, cfg_f, cfg_r};

  pll_seq_lock #(.PRI_W(PRI_LOCK_W), .SEC_W(SEC_LOCK_W)) u_lock (
    .lock_i(lock_i), .primary(prim), .locked(locked));

  pll_seq_fsm #(.RST_HI_CYC(RST_HI_CYC), .LOCK_TMO(LOCK_TMO)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .primary_i(primary_i), .fac_i(fac), .locked(locked), .prim_q(prim),
    .ctrl_q(ctrl_word), .sel_q(sysclk_sel), .slip_q(slip_clr),
    .busy_q(busy), .done_q(done), .err_q(err));

  pll_seq_rate #(.FIN_W(FIN_W), .RATE_W(RATE_W)) u_rate (
    .fin(fin_rate), .ctrl(ctrl_word), .rate(rate_exp));
endmodule

// File: tb/tb_pll_seq_top.sv
module tb_pll_seq_top;
  localparam int TMO = 64;
  localparam logic [31:0] FIN = 32'd26_000_000;
  // {primary, r[3:0], f[5:0], od[3:0], bw[5:0], polls_before_lock[3:0]}
  localparam logic [24:0] VEC [4] = '{
    {1'b1, 4'd0,  6'd59, 4'd1,  6'd59, 4'd3},
    {1'b0, 4'd0,  6'd59, 4'd3,  6'd59, 4'd0},
    {1'b0, 4'd0,  6'd22, 4'd1,  6'd22, 4'd5},
    {1'b1, 4'd15, 6'd63, 4'd15, 6'd63, 4'd1}
  };

  logic clk = 0, rst_n = 0, start_req = 0, stop_req = 0, primary_i = 0;
  logic [3:0] cfg_r = 0, cfg_od = 0;
  logic [5:0] cfg_f = 0, cfg_bw = 0;
  logic [1:0] lock_i = 0;
  logic [31:0] fin_rate = FIN;
  logic [31:0] ctrl_word;
  logic sysclk_sel, slip_clr, busy, done, err;
  logic [37:0] rate_exp;
  int checks = 0, errors = 0;
  logic exp_sel = 0;

  always #4 clk = ~clk;

  pll_seq_top #(.LOCK_TMO(TMO)) dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] frate(input logic [3:0] r, input logic [5:0] f, input logic [3:0] od);
    return (64'(FIN) * (64'(f) + 1)) / ((64'(r) + 1) * (64'(od) + 1));
  endfunction

  task automatic run_start(input logic prim, input logic [3:0] r, input logic [5:0] f,
                           input logic [3:0] od, input logic [5:0] bw, input int dly);
    logic [31:0] w;
    w = 32'h00A0_0000 | {12'h0, bw, od, f, r};
    primary_i = prim; cfg_r = r; cfg_f = f; cfg_od = od; cfg_bw = bw;
    lock_i = prim ? 2'b01 : 2'b10;
    start_req = 1;
    @(negedge clk); start_req = 0;
    chk("R10 busy after accept", busy, 1);
    if (prim) exp_sel = 0;
    chk("R3 selector during start", sysclk_sel, exp_sel);
    stop_req = 1;
    @(negedge clk); stop_req = 0;
    chk("R4 factor write", ctrl_word, w);
    @(negedge clk);
    chk("R5 reset low first", ctrl_word, w);
    @(negedge clk);
    chk("R5 reset high 1", ctrl_word, w | 32'h0010_0000);
    @(negedge clk);
    chk("R5 reset high 2", ctrl_word, w | 32'h0010_0000);
    @(negedge clk);
    chk("R5 reset low again", ctrl_word, w);
    if (dly >= TMO) begin
      for (int k = 0; k < TMO - 1; k++) begin
        @(negedge clk);
        chk("R7 slip strobe", slip_clr, 1);
        chk("R11 no early error", err, 0);
      end
      @(negedge clk);
      chk("R11 timeout err", err, 1);
      chk("R11 timeout busy", busy, 0);
      chk("R11 timeout no done", done, 0);
      chk("R11 no enable", ctrl_word, w);
      chk("R3 selector kept raw", sysclk_sel, exp_sel);
      lock_i = 0;
      return;
    end
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk("R7 slip strobe / R6 partial lock", slip_clr, 1);
    end
    lock_i = prim ? 2'b11 : 2'b01;
    @(negedge clk);
    chk("R8 enable write", ctrl_word, (w & ~32'h0080_0000) | 32'h0200_0000);
    chk("R12 locked rate", rate_exp, frate(r, f, od));
    if (prim) begin
      chk("R3 selector before handback", sysclk_sel, 0);
      chk("R10 busy before handback", busy, 1);
      @(negedge clk);
      exp_sel = 1;
      chk("R3 selector to pll", sysclk_sel, 1);
    end else begin
      chk("R3 secondary leaves selector", sysclk_sel, exp_sel);
    end
    chk("R10 done pulse", done, 1);
    chk("R10 busy cleared", busy, 0);
    @(negedge clk);
    chk("R10 done single cycle", done, 0);
  endtask

  task automatic run_stop();
    logic [31:0] w0;
    w0 = ctrl_word;
    stop_req = 1;
    @(negedge clk); stop_req = 0;
    chk("R9 bypass first", ctrl_word, w0 | 32'h0080_0000);
    chk("R12 bypass rate", rate_exp, 64'(FIN));
    @(negedge clk);
    chk("R9 power off", ctrl_word, (w0 | 32'h0080_0000) & ~32'h0220_0000);
    chk("R10 stop done", done, 1);
    chk("R10 stop busy", busy, 0);
    lock_i = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ctrl reset", ctrl_word, 32'h0080_0000);
    chk("R1 sel reset", sysclk_sel, 0);
    chk("R1 busy reset", busy, 0);
    chk("R1 done reset", done, 0);
    chk("R1 err reset", err, 0);
    chk("R1 slip reset", slip_clr, 0);
    chk("R12 reset rate", rate_exp, 64'(FIN));

    for (int i = 0; i < 4; i++) begin
      run_start(VEC[i][24], VEC[i][23:20], VEC[i][19:14], VEC[i][13:10],
                VEC[i][9:4], int'(VEC[i][3:0]));
      run_stop();
    end

    // R2: start while already running is ignored
    run_start(0, 4'd1, 6'd10, 4'd0, 6'd3, 2);
    begin
      logic [31:0] wr;
      wr = ctrl_word;
      start_req = 1;
      @(negedge clk); start_req = 0;
      chk("R2 ignored busy", busy, 0);
      chk("R2 ignored ctrl", ctrl_word, wr);
      @(negedge clk);
      chk("R2 ignored done", done, 0);
      chk("R2 ignored ctrl later", ctrl_word, wr);
    end
    run_stop();

    // R11: lock timeout, then error cleared by next request
    run_start(1, 4'd2, 6'd20, 4'd1, 6'd5, TMO);
    @(negedge clk);
    chk("R11 err sticky", err, 1);
    start_req = 1; primary_i = 0;
    @(negedge clk); start_req = 0;
    chk("R11 err cleared on accept", err, 0);
    repeat (5) @(negedge clk);
    lock_i = 2'b01;
    @(negedge clk);
    chk("R8 enable after retry", ctrl_word[25], 1);
    chk("R10 done after retry", done, 1);
    run_stop();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule